// File: doc/BRIEF.md
# Dual-Loop Synthesizer Counter Core

This block holds the counting logic of a two-loop frequency synthesizer for a ten-channel cordless radio. A fixed power-of-two divider turns the reference clock into a comparison tick and a square tone. Two programmable divide-by-N counters, one clocked by the receive VCO and one by the transmit VCO, each produce a one-cycle tick per N input cycles. With a 10.24 MHz reference and the default divider the comparison rate is 5 kHz, and the tick outputs go to the phase detectors outside the block.

A lookup table supplies the divide ratios. It is addressed by a base/handset mode bit and a 4-bit channel code. Codes outside the valid range fall back to the last channel. A transmit-enable input stops only the transmit counter, which saves power in a handset that is listening but not talking. The mode and channel inputs are treated as quasi-static settings. The transmit enable is synchronized into the transmit VCO clock domain.

Top module: `dual_loop_synth`

## Requirements
- R1: `ref_tick` is high for exactly one `ref_clk` cycle in every 2^REF_DIV_LOG2 cycles (2048 by default).
- R2: `tone_out` is a square wave with the same period as `ref_tick`. It is low for the first half of the period, starting with the cycle in which `ref_tick` is high, and high for the second half.
- R3: Channel codes 1 to 10, applied in plain binary on `chan_code` (0001 to 1010), select channels 1 to 10 for both loops.
- R4: Every other code (0 and 11 to 15) selects channel 10.
- R5: `mode_base` = 1 selects the base ratio set and `mode_base` = 0 selects the handset ratio set.
- R6: With ROM_KIND = 0, the N values for channels 1 to 10 are: handset transmit 9934, 9969, 9972, 9954, 9975, 9966, 9978, 9986, 9998, 9994; handset receive 7183, 7187, 7195, 7203, 7207, 7215, 7227, 7235, 7247, 7255; base transmit 9322, 9326, 9334, 9342, 9346, 9354, 9366, 9374, 9386, 9394; base receive 7795, 7830, 7833, 7815, 7836, 7827, 7839, 7847, 7859, 7855.
- R7: With ROM_KIND = 1 (compact test table), for channel index i = channel - 1 and m = `mode_base`, the receive N is 5 + i + 12m and the transmit N is 7 + 2i + 30m.
- R8: Each loop tick is one input-clock cycle wide, and consecutive ticks are N cycles apart. A changed N is picked up at the next reload, so the tick interval that starts with the first tick after a change equals the new N.
- R9: After `tx_enable` goes low, `tx_tick` stays low from the (TX_SYNC_STAGES+1)-th transmit clock edge onward. `rx_tick` keeps running.
- R10: While disabled, the transmit counter tracks the current N. Counting as edge 1 the first transmit clock edge that samples `tx_enable` high, the first `tx_tick` follows edge N + TX_SYNC_STAGES.
- R11: While `rst_n` is low, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference (crystal) clock |
| rx_vco_clk | input | 1 | Receive VCO clock, drives the receive counter |
| tx_vco_clk | input | 1 | Transmit VCO clock, drives the transmit counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_base | input | 1 | 1 = base ratio set, 0 = handset ratio set |
| chan_code | input | 4 | Binary channel code, 1 to 10 valid |
| tx_enable | input | 1 | 1 = transmit counter runs, 0 = transmit counter held |
| ref_tick | output | 1 | Divided reference pulse |
| rx_tick | output | 1 | Divided receive VCO pulse |
| tx_tick | output | 1 | Divided transmit VCO pulse |
| tone_out | output | 1 | Square tone at the comparison rate |

## Verification
The bench builds two copies that share one clock. The first uses REF_DIV_LOG2 = 4 and the compact table (ROM_KIND = 1). Its periods are short enough that every mode and every one of the 16 channel codes can be swept, along with standby entry, exit and retuning. The second keeps the defaults: the full 2048 reference divide and the ratio table. Selected entries of that table are measured, including two illegal-code defaults in different modes.

// File: rtl/dls_pkg.sv
package dls_pkg;

   localparam int NUM_CHAN = 10;
   localparam int LAST_IDX = NUM_CHAN - 1;

   // Binary channel code 1..10 -> index 0..9, anything else -> last channel
   function automatic int chan_index(input logic [3:0] code);
      if (code >= 4'd1 && code <= 4'(NUM_CHAN))
         return int'(code) - 1;
      return LAST_IDX;
   endfunction

   function automatic int full_tx_n(input logic base, input int idx);
      if (base) begin
         case (idx)
            0: return 9322;  1: return 9326;  2: return 9334;
            3: return 9342;  4: return 9346;  5: return 9354;
            6: return 9366;  7: return 9374;  8: return 9386;
            default: return 9394;
         endcase
      end
      case (idx)
         0: return 9934;  1: return 9969;  2: return 9972;
         3: return 9954;  4: return 9975;  5: return 9966;
         6: return 9978;  7: return 9986;  8: return 9998;
         default: return 9994;
      endcase
   endfunction

   function automatic int full_rx_n(input logic base, input int idx);
      if (base) begin
         case (idx)
            0: return 7795;  1: return 7830;  2: return 7833;
            3: return 7815;  4: return 7836;  5: return 7827;
            6: return 7839;  7: return 7847;  8: return 7859;
            default: return 7855;
         endcase
      end
      case (idx)
         0: return 7183;  1: return 7187;  2: return 7195;
         3: return 7203;  4: return 7207;  5: return 7215;
         6: return 7227;  7: return 7235;  8: return 7247;
         default: return 7255;
      endcase
   endfunction

endpackage

// File: rtl/ratio_rom.sv
module ratio_rom #(
   parameter int ROM_KIND = 0,   // 0 = full ratio table, 1 = compact test table
   parameter int RX_W     = 13,
   parameter int TX_W     = 14
) (
   input  logic            mode_base,
   input  logic [3:0]      chan_code,
   output logic [RX_W-1:0] rx_n,
   output logic [TX_W-1:0] tx_n
);
   import dls_pkg::*;

   int idx;
   always_comb idx = chan_index(chan_code);

   generate
      if (ROM_KIND == 0) begin : g_full
         if (RX_W < 13) begin : g_rxw_bad
            $error("ratio_rom: RX_W too narrow for the full table");
         end
         if (TX_W < 14) begin : g_txw_bad
            $error("ratio_rom: TX_W too narrow for the full table");
         end
         always_comb begin
            rx_n = RX_W'(full_rx_n(mode_base, idx));
            tx_n = TX_W'(full_tx_n(mode_base, idx));
         end
      end else if (ROM_KIND == 1) begin : g_compact
         if (RX_W < 5 || TX_W < 6) begin : g_w_bad
            $error("ratio_rom: widths too narrow for the compact table");
         end
         always_comb begin
            rx_n = RX_W'(5 + idx + 12 * int'(mode_base));
            tx_n = TX_W'(7 + 2 * idx + 30 * int'(mode_base));
         end
      end else begin : g_kind_bad
         $error("ratio_rom: ROM_KIND must be 0 or 1");
      end
   endgenerate

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
   parameter int DIV_LOG2 = 11
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick,
   output logic tone
);
   localparam logic [DIV_LOG2-1:0] CNT_ONE = DIV_LOG2'(1);

   logic [DIV_LOG2-1:0] cnt;

   generate
      if (DIV_LOG2 < 2) begin : g_bad
         $error("ref_divider: DIV_LOG2 must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= &cnt;
         cnt  <= cnt + CNT_ONE;
      end
   end

   // Upper half of the count is the high half of the tone
   assign tone = cnt[DIV_LOG2-1];

endmodule

// File: rtl/nloop_counter.sv
module nloop_counter #(
   parameter int W           = 13,
   parameter bit GATED       = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] n_val,
   input  logic         en_async,
   output logic         tick
);
   localparam logic [W-1:0] ONE = W'(1);

   logic         en;
   logic [W-1:0] cnt;
   logic         at_end;

   generate
      if (W < 2) begin : g_w_bad
         $error("nloop_counter: W must be at least 2");
      end
      if (GATED) begin : g_sync
         if (SYNC_STAGES < 2) begin : g_s_bad
            $error("nloop_counter: SYNC_STAGES must be at least 2");
         end
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-2:0], en_async};
         end
         assign en = sh[SYNC_STAGES-1];
      end else begin : g_free
         logic unused_en;
         assign unused_en = en_async;
         assign en = 1'b1;
      end
   endgenerate

   assign at_end = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (!en) begin
         cnt  <= n_val - ONE;     // parked at reload value, follows N
         tick <= 1'b0;
      end else begin
         tick <= at_end;
         cnt  <= at_end ? (n_val - ONE) : (cnt - ONE);
      end
   end

endmodule

// File: rtl/dual_loop_synth.sv
module dual_loop_synth #(
   parameter int REF_DIV_LOG2   = 11,
   parameter int RX_W           = 13,
   parameter int TX_W           = 14,
   parameter int ROM_KIND       = 0,
   parameter int TX_SYNC_STAGES = 2
) (
   input  logic       ref_clk,
   input  logic       rx_vco_clk,
   input  logic       tx_vco_clk,
   input  logic       rst_n,
   input  logic       mode_base,
   input  logic [3:0] chan_code,
   input  logic       tx_enable,
   output logic       ref_tick,
   output logic       rx_tick,
   output logic       tx_tick,
   output logic       tone_out
);
   logic [RX_W-1:0] rx_n;
   logic [TX_W-1:0] tx_n;

   generate
      if (REF_DIV_LOG2 > 20) begin : g_ref_bad
         $error("dual_loop_synth: REF_DIV_LOG2 out of range");
      end
   endgenerate

   ratio_rom #(.ROM_KIND(ROM_KIND), .RX_W(RX_W), .TX_W(TX_W)) u_rom (
      .mode_base (mode_base),
      .chan_code (chan_code),
      .rx_n      (rx_n),
      .tx_n      (tx_n)
   );

   ref_divider #(.DIV_LOG2(REF_DIV_LOG2)) u_ref (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .tick  (ref_tick),
      .tone  (tone_out)
   );

   nloop_counter #(.W(RX_W), .GATED(1'b0), .SYNC_STAGES(TX_SYNC_STAGES)) u_rx (
      .clk      (rx_vco_clk),
      .rst_n    (rst_n),
      .n_val    (rx_n),
      .en_async (1'b1),
      .tick     (rx_tick)
   );

   nloop_counter #(.W(TX_W), .GATED(1'b1), .SYNC_STAGES(TX_SYNC_STAGES)) u_tx (
      .clk      (tx_vco_clk),
      .rst_n    (rst_n),
      .n_val    (tx_n),
      .en_async (tx_enable),
      .tick     (tx_tick)
   );

endmodule

// File: rtl/dual_loop_synth_chk.sv
module dual_loop_synth_chk #(
   parameter int REF_DIV_LOG2   = 11,
   parameter int TX_SYNC_STAGES = 2
) (
   input logic ref_clk,
   input logic rx_vco_clk,
   input logic tx_vco_clk,
   input logic rst_n,
   input logic tx_enable,
   input logic ref_tick,
   input logic rx_tick,
   input logic tx_tick,
   input logic tone_out
);
   localparam int DIV     = 1 << REF_DIV_LOG2;
   localparam int QUIET_N = TX_SYNC_STAGES + 1;

   logic [31:0] gap;
   logic        seen;
   int          low_cnt;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (ref_tick) begin
         gap  <= '0;
         seen <= 1'b1;
      end else begin
         gap  <= gap + 32'd1;
      end
   end

   always_ff @(posedge tx_vco_clk or negedge rst_n) begin
      if (!rst_n)                low_cnt <= 0;
      else if (tx_enable)        low_cnt <= 0;
      else if (low_cnt < QUIET_N) low_cnt <= low_cnt + 1;
   end

   AST_REF_GAP: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (ref_tick && seen) |-> (gap == 32'(DIV - 1))); // R1

   AST_REF_TONE_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
      ref_tick |-> !tone_out); // R2

   AST_RX_TICK_WIDTH: assert property (@(posedge rx_vco_clk) disable iff (!rst_n)
      rx_tick |=> !rx_tick); // R8

   AST_TX_TICK_WIDTH: assert property (@(posedge tx_vco_clk) disable iff (!rst_n)
      tx_tick |=> !tx_tick); // R8

   AST_TX_QUIET: assert property (@(posedge tx_vco_clk) disable iff (!rst_n)
      (low_cnt >= QUIET_N) |-> !tx_tick); // R9

endmodule

bind dual_loop_synth dual_loop_synth_chk #(
   .REF_DIV_LOG2   (REF_DIV_LOG2),
   .TX_SYNC_STAGES (TX_SYNC_STAGES)
) u_chk (
   .ref_clk    (ref_clk),
   .rx_vco_clk (rx_vco_clk),
   .tx_vco_clk (tx_vco_clk),
   .rst_n      (rst_n),
   .tx_enable  (tx_enable),
   .ref_tick   (ref_tick),
   .rx_tick    (rx_tick),
   .tx_tick    (tx_tick),
   .tone_out   (tone_out)
);

// File: tb/tb_dual_loop_synth.sv
module tb_dual_loop_synth;

   localparam int SMALL_LOG2 = 4;
   localparam int SMALL_DIV  = 1 << SMALL_LOG2;
   localparam int SYNC       = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n;
   logic       s_mode, f_mode, s_en, f_en;
   logic [3:0] s_code, f_code;
   logic       s_ref, s_rx, s_tx, s_tone;
   logic       f_ref, f_rx, f_tx, f_tone;

   int vectors = 0;
   int errs    = 0;
   bit done    = 1'b0;
   int per_res [6];

   dual_loop_synth #(.REF_DIV_LOG2(SMALL_LOG2), .ROM_KIND(1), .TX_SYNC_STAGES(SYNC)) dut (
      .ref_clk(clk), .rx_vco_clk(clk), .tx_vco_clk(clk), .rst_n(rst_n),
      .mode_base(s_mode), .chan_code(s_code), .tx_enable(s_en),
      .ref_tick(s_ref), .rx_tick(s_rx), .tx_tick(s_tx), .tone_out(s_tone));

   dual_loop_synth dut_full (
      .ref_clk(clk), .rx_vco_clk(clk), .tx_vco_clk(clk), .rst_n(rst_n),
      .mode_base(f_mode), .chan_code(f_code), .tx_enable(f_en),
      .ref_tick(f_ref), .rx_tick(f_rx), .tx_tick(f_tx), .tone_out(f_tone));

   function automatic int exp_idx(input int code);
      return (code >= 1 && code <= 10) ? code - 1 : 9;
   endfunction

   function automatic int small_rx(input int m, input int code);
      return 5 + exp_idx(code) + 12 * m;
   endfunction

   function automatic int small_tx(input int m, input int code);
      return 7 + 2 * exp_idx(code) + 30 * m;
   endfunction

   function automatic int tab_tx(input int m, input int code);
      int ht [10] = '{9934, 9969, 9972, 9954, 9975, 9966, 9978, 9986, 9998, 9994};
      int bt [10] = '{9322, 9326, 9334, 9342, 9346, 9354, 9366, 9374, 9386, 9394};
      return m ? bt[exp_idx(code)] : ht[exp_idx(code)];
   endfunction

   function automatic int tab_rx(input int m, input int code);
      int hr [10] = '{7183, 7187, 7195, 7203, 7207, 7215, 7227, 7235, 7247, 7255};
      int br [10] = '{7795, 7830, 7833, 7815, 7836, 7827, 7839, 7847, 7859, 7855};
      return m ? br[exp_idx(code)] : hr[exp_idx(code)];
   endfunction

   function automatic logic tick(input int sel);
      case (sel)
         0: return s_rx;
         1: return s_tx;
         2: return f_rx;
         3: return f_tx;
         4: return s_ref;
         default: return f_ref;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Wait for the first tick after the call, then count cycles to the next one
   task automatic meas(input int sel, input int limit);
      int k = 0;
      int p = 0;
      do begin @(negedge clk); k++; end while (!tick(sel) && k < limit);
      do begin @(negedge clk); p++; end while (!tick(sel) && p < limit);
      per_res[sel] = p;
   endtask

   task automatic run_small();
      int cnt_tx;
      int cnt_rx;
      int k;
      // R1: reference period
      meas(4, 200);
      check("R1 small ref period", per_res[4], SMALL_DIV);
      // R2: tone shape over one period, phase taken from ref_tick
      k = 0;
      do begin @(negedge clk); k++; end while (!s_ref && k < 200);
      check("R2 tone low on tick", int'(s_tone), 0);
      for (int i = 1; i <= SMALL_DIV; i++) begin
         @(negedge clk);
         if (i < SMALL_DIV) begin
            check("R2 tone level", int'(s_tone), (i >= SMALL_DIV / 2) ? 1 : 0);
            check("R1 no early tick", int'(s_ref), 0);
         end else begin
            check("R1 tick at period", int'(s_ref), 1);
         end
      end
      // R3 R4 R7 R8: sweep every mode and code
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            s_mode = m[0];
            s_code = 4'(c);
            fork
               meas(0, 200);
               meas(1, 200);
            join
            if (c >= 1 && c <= 10) begin
               check("R3 R7 R8 rx period", per_res[0], small_rx(m, c));
               check("R3 R7 R8 tx period", per_res[1], small_tx(m, c));
            end else begin
               check("R4 R7 R8 rx period", per_res[0], small_rx(m, c));
               check("R4 R7 R8 tx period", per_res[1], small_tx(m, c));
            end
         end
      end
      // R9: standby silences transmit only
      @(negedge clk);
      s_mode = 1'b0;
      s_code = 4'd3;
      s_en   = 1'b0;
      repeat (SYNC) @(negedge clk);
      cnt_tx = 0;
      cnt_rx = 0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         cnt_tx += int'(s_tx);
         cnt_rx += int'(s_rx);
      end
      check("R9 tx quiet", cnt_tx, 0);
      check("R9 rx still running", int'(cnt_rx >= 150 / small_rx(0, 3)), 1);
      // R10: retune while held, then restart
      s_code = 4'd8;
      repeat (5) @(negedge clk);
      s_en = 1'b1;
      k = 0;
      do begin @(negedge clk); k++; end while (!s_tx && k < 500);
      check("R10 restart delay", k, small_tx(0, 8) + SYNC);
      @(negedge clk);
      s_en = 1'b0;
      s_mode = 1'b1;
      s_code = 4'd13;
      repeat (8) @(negedge clk);
      check("R9 tx held low", int'(s_tx), 0);
      s_en = 1'b1;
      k = 0;
      do begin @(negedge clk); k++; end while (!s_tx && k < 500);
      check("R10 R4 restart delay", k, small_tx(1, 13) + SYNC);
   endtask

   task automatic run_full();
      int ms [5] = '{0, 0, 1, 1, 0};
      int cs [5] = '{1, 9, 10, 0, 12};
      meas(5, 5000);
      check("R1 full ref period", per_res[5], 2048);
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         f_mode = ms[j][0];
         f_code = 4'(cs[j]);
         fork
            meas(2, 30000);
            meas(3, 30000);
         join
         check("R5 R6 rx table", per_res[2], tab_rx(ms[j], cs[j]));
         check("R5 R6 tx table", per_res[3], tab_tx(ms[j], cs[j]));
      end
   endtask

   initial begin
      rst_n  = 1'b0;
      s_mode = 1'b0; s_code = 4'd1; s_en = 1'b1;
      f_mode = 1'b0; f_code = 4'd1; f_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 small outputs in reset", int'({s_ref, s_rx, s_tx, s_tone}), 0);
      check("R11 full outputs in reset", int'({f_ref, f_rx, f_tx, f_tone}), 0);
      rst_n = 1'b1;
      fork
         run_small();
         run_full();
      join
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL all watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

endmodule